// File: doc/BRIEF.md
# Sector-Erase Command Sequencer

This block is the command front end of a NOR-style flash device, reduced to the sector-erase path. It watches single-cycle bus writes (address, data, write strobe) and tracks the six-write unlock and erase sequence. It then keeps an accept window open. During that window further sector-erase writes add sectors to an erase set, which is held as a bitmap with one bit per sector. When the window lapses, erasure starts. An external done pulse stands in for the erase engine and ends the erase.

The block handles erase-suspend and erase-resume. While the erase is suspended, it grants reads to any sector outside the erase set. It reports a busy flag and a timer flag that shows the window has closed. It also reports whether the array is in read mode. The active-low reset acts as the device's hardware reset and aborts everything at once.

An address is a sector index in its upper `SECT_W` bits, followed by an 11-bit offset in its lower bits. Command recognition looks only at the offset. The sector index selects the bitmap bit.

Top module: `erase_cmd_seq`

## Requirements
- R1: After reset: read_mode=1, busy=0, tmr_flag=0, suspended=0, sect_map all zero, and rd_ok=1 for any sector.
- R2: The writes 0xAA@offset 0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address open the accept window. That last write sets the bit of its sector (address bits [ADDR_W-1 -: SECT_W]). In the window read_mode=0, busy=0 and tmr_flag=0. Busy never rises with an empty erase set.
- R3: In the first five steps, a write that does not match the expected step returns the block to read mode, and no sector is selected.
- R4: Erasure begins WIN_CYC clock edges after the edge that captured the last accepted 0x30 write. At that edge busy and tmr_flag both rise.
- R5: Each further 0x30 write during the window adds its sector (in any order; duplicates are harmless) and restarts the full window.
- R6: Any write during the window with data other than 0x30 or 0xB0 clears the erase set and returns to read mode. No erase follows.
- R7: During the erase, every write other than 0xB0 is ignored: busy stays 1 and sect_map is unchanged.
- R8: 0xB0 during the erase suspends it: suspended=1, busy=0, tmr_flag=1. While suspended, rd_ok is 1 exactly for sectors whose bit is clear. erase_done and writes other than 0x30 have no effect.
- R9: 0xB0 during the window closes the window and suspends. The block stays suspended however long it waits.
- R10: 0x30 while suspended resumes the erase (busy=1, suspended=0).
- R11: erase_done during the erase returns to read mode, clears the erase set, and drops busy and tmr_flag.
- R12: Asserting rst_n low during an erase forces read mode, busy=0 and an empty set without waiting for a clock edge.
- R13: rd_ok is 1 in read mode and 0 during the window and the running erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address: sector index over an 11-bit offset |
| wr_data | input | 8 | Write data (command byte) |
| erase_done | input | 1 | Erase engine completion pulse |
| rd_sect | input | SECT_W | Sector index being queried for read access |
| read_mode | output | 1 | Array is in read mode (idle or mid-sequence) |
| busy | output | 1 | Erase running |
| tmr_flag | output | 1 | Accept window closed (erasing or suspended) |
| suspended | output | 1 | Erase suspended |
| rd_ok | output | 1 | Read of rd_sect is permitted now |
| sect_map | output | 2**SECT_W | Erase-select bitmap |

## Verification
The assertions take wr_en to be a one-cycle strobe with a stable address and data while it is high. They take erase_done to be a pulse, and WIN_CYC to be at least 2. The bench drives every input at the falling clock edge and holds each write for exactly one cycle. It spaces the extra sector writes by a random gap shorter than the window. It draws foreign command bytes only from values that exclude 0x30 and 0xB0, so each stimulus maps to exactly one requirement outcome.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    localparam int OFF_W = 11;

    localparam logic [OFF_W-1:0] OFF_A   = 11'h555;
    localparam logic [OFF_W-1:0] OFF_B   = 11'h2AA;
    localparam logic [7:0]       D_UNL_A = 8'hAA;
    localparam logic [7:0]       D_UNL_B = 8'h55;
    localparam logic [7:0]       D_SETUP = 8'h80;
    localparam logic [7:0]       D_SECT  = 8'h30;
    localparam logic [7:0]       D_SUSP  = 8'hB0;

    typedef enum logic [2:0] {
        K_UNLK_A,
        K_UNLK_B,
        K_SETUP,
        K_SECT,
        K_SUSP,
        K_OTHER
    } cmd_kind_e;

    typedef enum logic [3:0] {
        S_READ,
        S_U1,
        S_U2,
        S_SET,
        S_U3,
        S_U4,
        S_WIN,
        S_ERASE,
        S_SUSP
    } fsm_e;

    typedef struct packed {
        fsm_e st;
    } seq_state_t;

endpackage

// File: rtl/erase_cmd_decode.sv
module erase_cmd_decode
    import erase_seq_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic [7:0]       data,
    output cmd_kind_e        kind
);

    always_comb begin
        if (data == D_UNL_A && offset == OFF_A)
            kind = K_UNLK_A;
        else if (data == D_UNL_B && offset == OFF_B)
            kind = K_UNLK_B;
        else if (data == D_SETUP && offset == OFF_A)
            kind = K_SETUP;
        else if (data == D_SECT)
            kind = K_SECT;
        else if (data == D_SUSP)
            kind = K_SUSP;
        else
            kind = K_OTHER;
    end

endmodule

// File: rtl/erase_win_timer.sv
module erase_win_timer #(
    parameter  int WIN_CYC = 5000,
    localparam int CNT_W   = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic stop,
    output logic expired
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WIN_CYC - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.run = 1'b1;
            nxt_d.cnt = LOAD_VAL;
        end else if (stop) begin
            nxt_d.run = 1'b0;
            nxt_d.cnt = '0;
        end else if (cur_q.run && cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign expired = cur_q.run && (cur_q.cnt == '0);

    AST_WIN_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= LOAD_VAL); // R4

    AST_WIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_q.run && cur_q.cnt == LOAD_VAL)); // R5

endmodule

// File: rtl/erase_sect_map.sv
module erase_sect_map #(
    parameter  int SECT_W   = 5,
    localparam int NUM_SECT = 1 << SECT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [SECT_W-1:0]   set_idx,
    input  logic                clr,
    output logic [NUM_SECT-1:0] map
);

    logic [NUM_SECT-1:0] map_q, map_d;

    for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
        always_comb begin
            if (clr)
                map_d[i] = 1'b0;
            else if (set_en && set_idx == SECT_W'(i))
                map_d[i] = 1'b1;
            else
                map_d[i] = map_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign map = map_q;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (map_q == '0)); // R11

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr) |=> map_q[$past(set_idx)]); // R5

endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
    import erase_seq_pkg::*;
#(
    parameter  int WIN_CYC  = 5000,
    parameter  int SECT_W   = 5,
    localparam int ADDR_W   = SECT_W + OFF_W,
    localparam int NUM_SECT = 1 << SECT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                erase_done,
    input  logic [SECT_W-1:0]   rd_sect,
    output logic                read_mode,
    output logic                busy,
    output logic                tmr_flag,
    output logic                suspended,
    output logic                rd_ok,
    output logic [NUM_SECT-1:0] sect_map
);

    cmd_kind_e  kind;
    seq_state_t cur_q, nxt_d;
    logic       map_set, map_clr, t_load, t_stop, t_expired;

    erase_cmd_decode u_dec (
        .offset (wr_addr[OFF_W-1:0]),
        .data   (wr_data),
        .kind   (kind)
    );

    erase_win_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .stop    (t_stop),
        .expired (t_expired)
    );

    erase_sect_map #(.SECT_W(SECT_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (map_set),
        .set_idx (wr_addr[ADDR_W-1 -: SECT_W]),
        .clr     (map_clr),
        .map     (sect_map)
    );

    always_comb begin
        nxt_d   = cur_q;
        map_set = 1'b0;
        map_clr = 1'b0;
        t_load  = 1'b0;
        t_stop  = 1'b0;
        unique case (cur_q.st)
            S_READ:  if (wr_en && kind == K_UNLK_A) nxt_d.st = S_U1;
            S_U1:    if (wr_en) nxt_d.st = (kind == K_UNLK_B) ? S_U2  : S_READ;
            S_U2:    if (wr_en) nxt_d.st = (kind == K_SETUP)  ? S_SET : S_READ;
            S_SET:   if (wr_en) nxt_d.st = (kind == K_UNLK_A) ? S_U3  : S_READ;
            S_U3:    if (wr_en) nxt_d.st = (kind == K_UNLK_B) ? S_U4  : S_READ;
            S_U4: begin
                if (wr_en) begin
                    if (kind == K_SECT) begin
                        nxt_d.st = S_WIN;
                        map_set  = 1'b1;
                        t_load   = 1'b1;
                    end else begin
                        nxt_d.st = S_READ;
                    end
                end
            end
            S_WIN: begin
                if (wr_en) begin
                    if (kind == K_SECT) begin
                        map_set = 1'b1;
                        t_load  = 1'b1;
                    end else if (kind == K_SUSP) begin
                        nxt_d.st = S_SUSP;
                        t_stop   = 1'b1;
                    end else begin
                        nxt_d.st = S_READ;
                        map_clr  = 1'b1;
                        t_stop   = 1'b1;
                    end
                end else if (t_expired) begin
                    nxt_d.st = S_ERASE;
                    t_stop   = 1'b1;
                end
            end
            S_ERASE: begin
                if (erase_done) begin
                    nxt_d.st = S_READ;
                    map_clr  = 1'b1;
                end else if (wr_en && kind == K_SUSP) begin
                    nxt_d.st = S_SUSP;
                end
            end
            S_SUSP:  if (wr_en && kind == K_SECT) nxt_d.st = S_ERASE;
            default: nxt_d.st = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: S_READ};
        else        cur_q <= nxt_d;
    end

    assign read_mode = (cur_q.st == S_READ) || (cur_q.st == S_U1) || (cur_q.st == S_U2)
                    || (cur_q.st == S_SET)  || (cur_q.st == S_U3) || (cur_q.st == S_U4);
    assign busy      = (cur_q.st == S_ERASE);
    assign suspended = (cur_q.st == S_SUSP);
    assign tmr_flag  = busy || suspended;
    assign rd_ok     = read_mode || (suspended && !sect_map[rd_sect]);

    AST_BUSY_HAS_SECT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sect_map != '0)); // R2

    AST_WIN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_WIN && wr_en && kind != K_SECT && kind != K_SUSP)
        |=> (read_mode && sect_map == '0)); // R6

    AST_ERASE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && kind != K_SUSP && !erase_done)
        |=> (busy && $stable(sect_map))); // R7

    AST_SUSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !(wr_en && kind == K_SECT)) |=> suspended); // R8

    AST_DONE_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && erase_done) |=> (read_mode && !tmr_flag)); // R11

endmodule

// File: tb/sim_erase_cmd_seq.sv
module sim_erase_cmd_seq;

    localparam int WIN = 20;
    localparam int SW  = 4;
    localparam int NS  = 1 << SW;
    localparam int AW  = SW + 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          erase_done = 1'b0;
    logic [SW-1:0] rd_sect = '0;
    logic          read_mode, busy, tmr_flag, suspended, rd_ok;
    logic [NS-1:0] sect_map;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    erase_cmd_seq #(.WIN_CYC(WIN), .SECT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_done(erase_done), .rd_sect(rd_sect),
        .read_mode(read_mode), .busy(busy), .tmr_flag(tmr_flag),
        .suspended(suspended), .rd_ok(rd_ok), .sect_map(sect_map)
    );

    function automatic logic [NS-1:0] bit_of(input int s);
        return NS'(1) << s;
    endfunction

    function automatic logic exp_rd(input logic susp, input logic rdm,
                                    input logic [NS-1:0] m, input int s);
        return rdm || (susp && !m[s]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int s, input logic [10:0] off, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {SW'(s), off}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
    endtask

    task automatic seq(input int s);
        wr(0, 11'h555, 8'hAA); wr(0, 11'h2AA, 8'h55); wr(0, 11'h555, 8'h80);
        wr(0, 11'h555, 8'hAA); wr(0, 11'h2AA, 8'h55); wr(s, 11'h000, 8'h30);
    endtask

    task automatic status(input string tag, input logic rdm, input logic b,
                          input logic t, input logic su);
        chk({tag, " read_mode"}, 32'(read_mode), 32'(rdm));
        chk({tag, " busy"},      32'(busy),      32'(b));
        chk({tag, " tmr_flag"},  32'(tmr_flag),  32'(t));
        chk({tag, " suspended"}, 32'(suspended), 32'(su));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NS-1:0] m;
        void'($urandom(32'd7321));
        idle(2); rst_n = 1'b1; idle(1);
        // R1 reset state
        status("R1", 1, 0, 0, 0);
        chk("R1 map", 32'(sect_map), 0);
        chk("R1 rd_ok", 32'(rd_ok), 1);

        // R2 R4 R13 directed sequence, window timing
        seq(3);
        status("R2", 0, 0, 0, 0);
        chk("R2 map", 32'(sect_map), 32'(bit_of(3)));
        chk("R13 window rd_ok", 32'(rd_ok), 0);
        idle(WIN - 1);
        chk("R4 still window", 32'(busy), 0);
        idle(1);
        status("R4 erase start", 0, 1, 1, 0);
        chk("R13 erase rd_ok", 32'(rd_ok), 0);

        // R7 writes ignored during erase
        wr(5, 11'h000, 8'hF0); wr(7, 11'h000, 8'h30); wr(0, 11'h555, 8'hAA);
        chk("R7 busy", 32'(busy), 1);
        chk("R7 map", 32'(sect_map), 32'(bit_of(3)));

        // R11 erase done
        done_pulse();
        status("R11", 1, 0, 0, 0);
        chk("R11 map", 32'(sect_map), 0);

        // R3 broken sequences
        wr(0, 11'h555, 8'hAA); wr(0, 11'h2AA, 8'h55); wr(0, 11'h555, 8'h90);
        wr(0, 11'h555, 8'hAA); wr(0, 11'h2AA, 8'h30); wr(2, 11'h000, 8'h30);
        idle(WIN + 2);
        status("R3", 1, 0, 0, 0);
        chk("R3 map", 32'(sect_map), 0);

        // R6 foreign write in window
        seq(4); wr(0, 11'h000, 8'hF0);
        status("R6", 1, 0, 0, 0);
        chk("R6 map", 32'(sect_map), 0);
        idle(WIN + 2);
        chk("R6 no erase", 32'(busy), 0);

        // R5 add sector restarts window
        seq(2); idle(WIN / 2); wr(9, 11'h123, 8'h30);
        chk("R5 map", 32'(sect_map), 32'(bit_of(2) | bit_of(9)));
        idle(WIN - 1);
        chk("R5 restarted", 32'(busy), 0);
        idle(1);
        chk("R5 erase", 32'(busy), 1);

        // R8 suspend during erase
        wr(0, 11'h000, 8'hB0);
        status("R8", 0, 0, 1, 1);
        rd_sect = 4'd2; #1;
        chk("R8 rd_ok in set", 32'(rd_ok), 0);
        rd_sect = 4'd4; #1;
        chk("R8 rd_ok outside", 32'(rd_ok), 1);
        done_pulse(); wr(0, 11'h000, 8'hF0);
        chk("R8 done ignored", 32'(suspended), 1);
        chk("R8 map kept", 32'(sect_map), 32'(bit_of(2) | bit_of(9)));

        // R10 resume
        wr(0, 11'h000, 8'h30);
        status("R10", 0, 1, 1, 0);
        done_pulse();

        // R9 suspend in window
        seq(6); wr(0, 11'h000, 8'hB0); idle(WIN + 5);
        status("R9", 0, 0, 1, 1);
        wr(0, 11'h000, 8'h30);
        chk("R9 resume", 32'(busy), 1);
        done_pulse();

        // R12 asynchronous hardware reset
        seq(1); idle(WIN + 1);
        chk("R12 pre busy", 32'(busy), 1);
        #2 rst_n = 1'b0; #1;
        status("R12", 1, 0, 0, 0);
        chk("R12 map", 32'(sect_map), 0);
        idle(1); rst_n = 1'b1; idle(1);

        // random runs
        for (int it = 0; it < 30; it++) begin
            int n, s0;
            n  = $urandom_range(1, 4);
            s0 = $urandom_range(0, NS - 1);
            m  = bit_of(s0);
            seq(s0);
            for (int k = 1; k < n; k++) begin
                int s;
                s = $urandom_range(0, NS - 1);
                idle($urandom_range(0, WIN - 2));
                wr(s, 11'($urandom_range(0, 2047)), 8'h30);
                m |= bit_of(s);
            end
            chk("R5 rand map", 32'(sect_map), 32'(m));
            if ($urandom_range(0, 3) == 0) begin
                logic [7:0] d;
                d = 8'($urandom_range(0, 255));
                if (d == 8'h30 || d == 8'hB0) d = 8'hF0;
                wr(0, 11'h000, d);
                chk("R6 rand abort", 32'(read_mode), 1);
                chk("R6 rand map", 32'(sect_map), 0);
            end else begin
                idle(WIN);
                chk("R4 rand busy", 32'(busy), 1);
                wr(0, 11'h000, 8'hB0);
                for (int q = 0; q < 3; q++) begin
                    int s;
                    s = $urandom_range(0, NS - 1);
                    rd_sect = SW'(s); #1;
                    chk("R8 rand rd_ok", 32'(rd_ok), 32'(exp_rd(1'b1, 1'b0, m, s)));
                end
                wr(0, 11'h000, 8'h30);
                chk("R10 rand resume", 32'(busy), 1);
                done_pulse();
                chk("R11 rand done", 32'(read_mode), 1);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule